// File: doc/BRIEF.md
# TLB Maintenance Register Front End

This block gives software a register view of a set-associative translation buffer. Three 32-bit control registers are exposed: an entry-access register (frame number, permission flags, global flag), a control register (process ID, way selector, read and write trigger flags) and a page-address register (virtual page number plus a base field). Software writes these registers through a single strobe with a select code. The block turns certain writes into entry writes or entry reads on an external entry store. The store is addressed by `{way, set}`, where the set is the low bits of the virtual page number.

A triggered entry write fires when the access register is written while the control register's write-enable flag is set. It uses the way held in the control register, the page number last written to the page-address register, and the process ID last written to the control register. After each triggered write the way selector steps to the next way. A triggered entry read fires when the control register is written with its read flag set. The read scatters the selected entry's fields back into the three readback registers.

The control register and the page-address register each keep a shadow copy of the last value written. The shadow, not the readback value, feeds later entry operations. Every operation completes on the strobe's clock edge, so `busy` is held low.

Top module: `tlb_maint_if`

## Requirements
- R1: After synchronous reset, all three readback registers and both shadows are zero, and no entry write is issued.
- R2: Writing the control register (select 1) with its read flag (bit 19) clear makes its readback equal the written value, with no entry write.
- R3: Writing the page-address register (select 2) updates readback bits 31:22 and 1:0 from the written value and leaves the page-number field (bits 21:2) unchanged. The full value becomes the shadow that later entry operations use.
- R4: Writing the access register (select 0) while control bit 18 (write-enable) is set issues exactly one entry write. It goes to index `{way, vpn[SET_W-1:0]}`, where the way is control bits 24 and up and the vpn is shadow bits 21:2. The tag is vpn in bits 31:12, global in bit 11, valid in bit 10 and the shadow process ID (control bits 4 and up) in the low bits.
- R5: The written entry data keeps only access bits 23:0 (C=23, R=22, W=21, X=20, frame number 19:0) with bits 31:24 zero. Access bit 24 (global) goes to tag bit 11.
- R6: The tag valid bit is set only when the page number is below 0xC0000. Page 0xBFFFF is valid and page 0xC0000 is not.
- R7: After a triggered write, the control way field (bits 27:24) becomes (way+1) modulo the number of ways. The access register readback never changes on an access-register write.
- R8: An access-register write with write-enable clear issues no entry write and changes no readback value. Entry writes occur only on access-register writes.
- R9: A control write with the read flag set reads the entry at `{written way field, shadow vpn[SET_W-1:0]}`. Access readback bits 24:0 become {tag global, data 23:0}, and bits 31:25 are kept. Control readback becomes the written value with its process-ID field replaced by the entry's stored ID. Page-address bits 21:2 become the entry's tag page number.
- R10: Triggered writes take the process ID from the control shadow (the last written value), even when a triggered read has put a different ID into the control readback.
- R11: `busy` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 access, 1 control, 2 page address, 3 none |
| wr_data | input | 32 | Register write data |
| acc_rd | output | 32 | Access register readback |
| misc_rd | output | 32 | Control register readback |
| addr_rd | output | 32 | Page-address register readback |
| busy | output | 1 | Operation in progress (always low) |
| ent_we | output | 1 | Entry store write strobe |
| ent_wr_idx | output | WAY_W+SET_W | Entry store write index |
| ent_wr_tag | output | 32 | Entry tag to store |
| ent_wr_data | output | 32 | Entry data to store |
| ent_rd_idx | output | WAY_W+SET_W | Entry store read index (combinational) |
| ent_rd_tag | input | 32 | Tag read from the entry store |
| ent_rd_data | input | 32 | Data read from the entry store |

## Verification
The bench targets the way selector wrapping from the last way back to zero. A design that does not wrap would index past the last way. The valid-bit boundary is hit with page numbers 0xBFFFF and 0xC0000, where an off-by-one comparison would flip one of the two tags. The bench also sets up a triggered read that loads a different process ID into the control readback and then fires a triggered write. A design that used the readback instead of the shadow would store the wrong ID. A page-address write must leave the readback page number alone, and an access write without write-enable must cause no stray entry write. Either fault shows up directly at the readback or entry-write ports.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;

    typedef enum logic [1:0] {
        SEL_ACC  = 2'd0,
        SEL_MISC = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // control register layout
    localparam int PID_LSB = 4;
    localparam int PID_FW  = 10;
    localparam int WE_BIT  = 18;
    localparam int RD_BIT  = 19;
    localparam int WAY_LSB = 24;
    localparam int WAY_FW  = 4;

    // page-address register layout
    localparam int VPN_LSB = 2;
    localparam int VPN_W   = 20;

    // access register layout
    localparam int KEEP_W  = 24;
    localparam int GLB_BIT = 24;

    localparam logic [VPN_W-1:0] VPN_LIMIT = 20'hC0000;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic              glob;
        logic              valid;
        logic [PID_FW-1:0] pid;
    } ent_tag_t;

    typedef struct packed {
        logic [31-KEEP_W:0] rsvd;
        logic [KEEP_W-1:0]  keep;
    } ent_data_t;

    function automatic ent_tag_t make_tag(input logic [VPN_W-1:0] vpn,
                                          input logic glob,
                                          input logic [PID_FW-1:0] pid);
        ent_tag_t t;
        t.vpn   = vpn;
        t.glob  = glob;
        t.valid = (vpn < VPN_LIMIT);
        t.pid   = pid;
        return t;
    endfunction

    function automatic ent_data_t make_data(input logic [KEEP_W-1:0] bits);
        ent_data_t d;
        d.rsvd = '0;
        d.keep = bits;
        return d;
    endfunction

endpackage

// File: rtl/tlb_maint_wrgen.sv
module tlb_maint_wrgen
    import tlb_maint_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    parameter int PID_W    = 8
) (
    input  logic                                   trig,
    input  logic [GLB_BIT:0]                       acc_bits,
    input  logic [VPN_W-1:0]                       vpn_sh,
    input  logic [PID_W-1:0]                       pid_sh,
    input  logic [$clog2(NUM_WAYS)-1:0]            way_cur,
    output logic                                   we,
    output logic [$clog2(NUM_WAYS)+$clog2(NUM_SETS)-1:0] idx,
    output logic [31:0]                            tag,
    output logic [31:0]                            data,
    output logic [WAY_FW-1:0]                      way_next
);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int SET_W = $clog2(NUM_SETS);

    logic [WAY_W-1:0]  way_inc;
    logic [PID_FW-1:0] pid_ext;

    // way stepping: power-of-two way counts wrap by truncation,
    // other counts wrap by comparison
    generate
        if (NUM_WAYS == (1 << WAY_W)) begin : g_pow2
            assign way_inc = way_cur + 1'b1;
        end else begin : g_cmp
            assign way_inc = (way_cur >= WAY_W'(NUM_WAYS - 1)) ? '0 : way_cur + 1'b1;
        end
    endgenerate

    always_comb begin
        way_next = '0;
        way_next[WAY_W-1:0] = way_inc;
        pid_ext = '0;
        pid_ext[PID_W-1:0] = pid_sh;
    end

    assign we   = trig;
    assign idx  = {way_cur, vpn_sh[SET_W-1:0]};
    assign tag  = make_tag(vpn_sh, acc_bits[GLB_BIT], pid_ext);
    assign data = make_data(acc_bits[KEEP_W-1:0]);

endmodule

// File: rtl/tlb_maint_rdmerge.sv
module tlb_maint_rdmerge
    import tlb_maint_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    parameter int PID_W    = 8
) (
    input  logic [31:0]                            misc_wdata,
    input  logic [VPN_W-1:0]                       vpn_sh,
    input  logic [31:GLB_BIT+1]                    acc_hi,
    input  logic [31:0]                            addr_cur,
    input  logic [31:0]                            rd_tag,
    input  logic [31:0]                            rd_data,
    output logic [$clog2(NUM_WAYS)+$clog2(NUM_SETS)-1:0] rd_idx,
    output logic [31:0]                            acc_nxt,
    output logic [31:0]                            misc_nxt,
    output logic [31:0]                            addr_nxt
);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int SET_W = $clog2(NUM_SETS);

    ent_tag_t  tag_f;
    ent_data_t data_f;
    logic      unused_rd_fields;

    assign tag_f  = ent_tag_t'(rd_tag);
    assign data_f = ent_data_t'(rd_data);
    assign unused_rd_fields = ^{tag_f.valid, tag_f.pid, data_f.rsvd};

    assign rd_idx  = {misc_wdata[WAY_LSB +: WAY_W], vpn_sh[SET_W-1:0]};
    assign acc_nxt = {acc_hi, tag_f.glob, data_f.keep};

    always_comb begin
        misc_nxt = misc_wdata;
        misc_nxt[PID_LSB +: PID_W] = tag_f.pid[PID_W-1:0];
        addr_nxt = addr_cur;
        addr_nxt[VPN_LSB +: VPN_W] = tag_f.vpn;
    end

endmodule

// File: rtl/tlb_maint_if.sv
module tlb_maint_if
    import tlb_maint_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    parameter int PID_W    = 8
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          wr_en,
    input  logic [1:0]                                    wr_sel,
    input  logic [31:0]                                   wr_data,
    output logic [31:0]                                   acc_rd,
    output logic [31:0]                                   misc_rd,
    output logic [31:0]                                   addr_rd,
    output logic                                          busy,
    output logic                                          ent_we,
    output logic [$clog2(NUM_WAYS)+$clog2(NUM_SETS)-1:0]  ent_wr_idx,
    output logic [31:0]                                   ent_wr_tag,
    output logic [31:0]                                   ent_wr_data,
    output logic [$clog2(NUM_WAYS)+$clog2(NUM_SETS)-1:0]  ent_rd_idx,
    input  logic [31:0]                                   ent_rd_tag,
    input  logic [31:0]                                   ent_rd_data
);
    localparam int WAY_W = $clog2(NUM_WAYS);

    reg_sel_e    sel;
    logic [31:0] acc_q, misc_q, addr_q;
    logic [31:0] misc_sh, addr_sh;
    logic        wr_trig;
    logic        rd_trig;
    logic [WAY_FW-1:0] way_next;
    logic [31:0] acc_from_rd, misc_from_rd, addr_from_rd;
    logic [31:0] addr_from_wr;

    assign sel     = reg_sel_e'(wr_sel);
    assign wr_trig = wr_en && (sel == SEL_ACC) && misc_q[WE_BIT];
    assign rd_trig = wr_en && (sel == SEL_MISC) && wr_data[RD_BIT];

    tlb_maint_wrgen #(
        .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .PID_W(PID_W)
    ) u_wrgen (
        .trig     (wr_trig),
        .acc_bits (wr_data[GLB_BIT:0]),
        .vpn_sh   (addr_sh[VPN_LSB +: VPN_W]),
        .pid_sh   (misc_sh[PID_LSB +: PID_W]),
        .way_cur  (misc_q[WAY_LSB +: WAY_W]),
        .we       (ent_we),
        .idx      (ent_wr_idx),
        .tag      (ent_wr_tag),
        .data     (ent_wr_data),
        .way_next (way_next)
    );

    tlb_maint_rdmerge #(
        .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .PID_W(PID_W)
    ) u_rdmerge (
        .misc_wdata (wr_data),
        .vpn_sh     (addr_sh[VPN_LSB +: VPN_W]),
        .acc_hi     (acc_q[31:GLB_BIT+1]),
        .addr_cur   (addr_q),
        .rd_tag     (ent_rd_tag),
        .rd_data    (ent_rd_data),
        .rd_idx     (ent_rd_idx),
        .acc_nxt    (acc_from_rd),
        .misc_nxt   (misc_from_rd),
        .addr_nxt   (addr_from_rd)
    );

    always_comb begin
        addr_from_wr = wr_data;
        addr_from_wr[VPN_LSB +: VPN_W] = addr_q[VPN_LSB +: VPN_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            misc_q  <= '0;
            addr_q  <= '0;
            misc_sh <= '0;
            addr_sh <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ACC: begin
                    if (wr_trig) begin
                        misc_q[WAY_LSB +: WAY_FW] <= way_next;
                    end
                end
                SEL_MISC: begin
                    misc_sh <= wr_data;
                    if (rd_trig) begin
                        acc_q  <= acc_from_rd;
                        misc_q <= misc_from_rd;
                        addr_q <= addr_from_rd;
                    end else begin
                        misc_q <= wr_data;
                    end
                end
                SEL_ADDR: begin
                    addr_sh <= wr_data;
                    addr_q  <= addr_from_wr;
                end
                default: ;
            endcase
        end
    end

    assign acc_rd  = acc_q;
    assign misc_rd = misc_q;
    assign addr_rd = addr_q;
    assign busy    = 1'b0;

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> (acc_rd == $past(acc_rd)));

    // R7
    way_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && misc_rd[WE_BIT] &&
         misc_rd[WAY_LSB +: WAY_FW] < WAY_FW'(NUM_WAYS))
        |=> (misc_rd[WAY_LSB +: WAY_FW] ==
             WAY_FW'((int'($past(misc_rd[WAY_LSB +: WAY_FW])) + 1) % NUM_WAYS)));

    // R3
    addr_vpn_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2)
        |=> (addr_rd[21:2] == $past(addr_rd[21:2]) &&
             addr_rd[31:22] == $past(wr_data[31:22]) &&
             addr_rd[1:0] == $past(wr_data[1:0])));

    // R2
    misc_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && !wr_data[RD_BIT]) |=> (misc_rd == $past(wr_data)));

    // R6
    valid_top_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_we && ent_wr_tag[31:30] == 2'b11) |-> !ent_wr_tag[10]);

    // R8
    no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        ent_we |-> (wr_en && wr_sel == 2'd0 && misc_rd[WE_BIT]));

    // R11
    busy_low_chk: assert property (@(posedge clk) disable iff (rst) !busy);

endmodule

// File: tb/tlb_maint_if_tb.sv
module tlb_maint_if_tb_top;
    localparam int NW = 4;
    localparam int NS = 16;
    localparam int PW = 8;
    localparam int IW = 6;
    localparam int NE = NW * NS;

    typedef struct {
        logic [31:0] acc;
        logic [31:0] misc;
        logic [31:0] addr;
        string       req;
    } reg_item_t;

    typedef struct {
        logic [IW-1:0] idx;
        logic [31:0]   tag;
        logic [31:0]   data;
        string         req;
    } wr_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd3;
    logic [31:0]   wr_data = '0;
    logic [31:0]   acc_rd, misc_rd, addr_rd;
    logic          busy;
    logic          ent_we;
    logic [IW-1:0] ent_wr_idx, ent_rd_idx;
    logic [31:0]   ent_wr_tag, ent_wr_data, ent_rd_tag, ent_rd_data;

    tlb_maint_if #(.NUM_WAYS(NW), .NUM_SETS(NS), .PID_W(PW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_rd(acc_rd), .misc_rd(misc_rd), .addr_rd(addr_rd), .busy(busy),
        .ent_we(ent_we), .ent_wr_idx(ent_wr_idx), .ent_wr_tag(ent_wr_tag),
        .ent_wr_data(ent_wr_data), .ent_rd_idx(ent_rd_idx),
        .ent_rd_tag(ent_rd_tag), .ent_rd_data(ent_rd_data)
    );

    // entry store attached to the block's ports
    logic [31:0] st_tag  [NE];
    logic [31:0] st_data [NE];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NE; i++) begin
                st_tag[i]  <= '0;
                st_data[i] <= '0;
            end
        end else if (ent_we) begin
            st_tag[ent_wr_idx]  <= ent_wr_tag;
            st_data[ent_wr_idx] <= ent_wr_data;
        end
    end
    assign ent_rd_tag  = st_tag[ent_rd_idx];
    assign ent_rd_data = st_data[ent_rd_idx];

    int checks = 0;
    int failures = 0;
    reg_item_t rq[$];
    wr_item_t  wq[$];

    // requirement model
    logic [31:0] m_acc = '0, m_misc = '0, m_addr = '0, sh_misc = '0, sh_addr = '0;
    logic [31:0] e_tag [NE];
    logic [31:0] e_data[NE];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_misc(input logic [3:0] top, input logic [3:0] way,
                                            input logic rd, input logic we,
                                            input logic [7:0] pid);
        return {top, way, 4'h0, rd, we, 6'h00, pid, 4'h3};
    endfunction

    function automatic logic [31:0] mk_acc(input logic [6:0] up, input logic g,
                                           input logic [3:0] crwx, input logic [19:0] pfn);
        return {up, g, crwx, pfn};
    endfunction

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] v, input string req);
        logic [1:0]    way;
        logic [19:0]   vpn;
        logic [IW-1:0] idx;
        wr_item_t      wi;
        reg_item_t     ri;
        case (sel)
            2'd0: begin
                if (m_misc[18]) begin
                    way = m_misc[25:24];
                    vpn = sh_addr[21:2];
                    idx = {way, vpn[3:0]};
                    wi.idx  = idx;
                    wi.tag  = {vpn, v[24], (vpn < 20'hC0000), 2'b00, sh_misc[11:4]};
                    wi.data = {8'h00, v[23:0]};
                    wi.req  = req;
                    wq.push_back(wi);
                    e_tag[idx]  = wi.tag;
                    e_data[idx] = wi.data;
                    m_misc[27:24] = {2'b00, way + 2'd1};
                end
            end
            2'd1: begin
                sh_misc = v;
                if (v[19]) begin
                    idx = {v[25:24], sh_addr[5:2]};
                    m_acc  = {m_acc[31:25], e_tag[idx][11], e_data[idx][23:0]};
                    m_misc = {v[31:12], e_tag[idx][7:0], v[3:0]};
                    m_addr[21:2] = e_tag[idx][31:12];
                end else begin
                    m_misc = v;
                end
            end
            2'd2: begin
                sh_addr = v;
                m_addr  = {v[31:22], m_addr[21:2], v[1:0]};
            end
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
        ri.acc = m_acc; ri.misc = m_misc; ri.addr = m_addr; ri.req = req;
        rq.push_back(ri);
    endtask

    // monitor: compares design outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (ent_we) begin
                    if (wq.size() == 0) begin
                        chk(1'b0, "R8", "unexpected entry write idx", 32'(ent_wr_idx), 32'hFFFFFFFF);
                    end else begin
                        wr_item_t w;
                        w = wq.pop_front();
                        chk(ent_wr_idx == w.idx, w.req, "R4 write index", 32'(ent_wr_idx), 32'(w.idx));
                        chk(ent_wr_tag == w.tag, w.req, "R4/R6 write tag", ent_wr_tag, w.tag);
                        chk(ent_wr_data == w.data, w.req, "R5 write data", ent_wr_data, w.data);
                    end
                end
                if (rq.size() > 0) begin
                    reg_item_t r;
                    r = rq.pop_front();
                    chk(acc_rd == r.acc, r.req, "access readback", acc_rd, r.acc);
                    chk(misc_rd == r.misc, r.req, "control readback", misc_rd, r.misc);
                    chk(addr_rd == r.addr, r.req, "page-address readback", addr_rd, r.addr);
                    chk(busy == 1'b0, "R11", "busy", 32'(busy), 32'h0);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", "run timed out", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        reg_item_t r0;
        for (int i = 0; i < NE; i++) begin
            e_tag[i]  = '0;
            e_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        r0.acc = '0; r0.misc = '0; r0.addr = '0; r0.req = "R1";
        rq.push_back(r0);
        @(negedge clk);

        reg_write(2'd2, {10'h2AF, 20'h12345, 2'b01}, "R3 page field kept");
        reg_write(2'd1, mk_misc(4'h8, 4'h1, 1'b0, 1'b1, 8'h5A), "R2 plain control write");
        reg_write(2'd0, mk_acc(7'h55, 1'b1, 4'b1010, 20'hABCDE), "R4 R5 global entry");
        reg_write(2'd0, mk_acc(7'h7F, 1'b0, 4'b0111, 20'h00042), "R5 flags only");
        reg_write(2'd0, mk_acc(7'h01, 1'b0, 4'b1111, 20'hFFFFF), "R7 way 3");
        reg_write(2'd0, mk_acc(7'h00, 1'b1, 4'b0001, 20'h13579), "R7 wrap to way 0");
        reg_write(2'd2, {10'h001, 20'hC0000, 2'b10}, "R3 shadow update");
        reg_write(2'd0, mk_acc(7'h00, 1'b0, 4'b0100, 20'h00C00), "R6 page C0000 invalid");
        reg_write(2'd2, {10'h3FF, 20'hBFFFF, 2'b00}, "R3 second shadow");
        reg_write(2'd0, mk_acc(7'h00, 1'b1, 4'b1100, 20'h0BFFF), "R6 page BFFFF valid");
        reg_write(2'd1, mk_misc(4'h6, 4'h2, 1'b1, 1'b1, 8'h33), "R9 triggered read");
        reg_write(2'd0, mk_acc(7'h2A, 1'b0, 4'b0010, 20'h24680), "R10 shadow process ID");
        reg_write(2'd1, mk_misc(4'h0, 4'h2, 1'b1, 1'b0, 8'h11), "R9 read back R10 entry");
        reg_write(2'd1, mk_misc(4'hF, 4'h0, 1'b0, 1'b0, 8'hC3), "R2 write-enable off");
        reg_write(2'd0, mk_acc(7'h7F, 1'b1, 4'b1111, 20'hFFFFF), "R8 no entry write");
        reg_write(2'd1, mk_misc(4'h0, 4'h0, 1'b1, 1'b0, 8'h00), "R9 untouched entry");
        repeat (2) @(negedge clk);
        chk(wq.size() == 0, "R8", "pending expected writes", 32'(wq.size()), 32'h0);
        chk(rq.size() == 0, "R9", "pending expected readbacks", 32'(rq.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule